// File: doc/BRIEF.md
# Host Palette and Register Access Port

This block is the host-side register interface of a graphics palette converter. A host reaches it over a bidirectional data bus of up to 10 bits. Each access is qualified by a one-cycle strobe, a read/write select and a two-bit register select. Through this port the host can reach three things. The first is an 8-bit address register. The second is a bank of 8-bit control registers, indexed by that address. The third is a colour palette of 256 entries, each 30 bits wide.

Palette traffic is serialised as red, green and blue colour values. An internal colour pointer steps through them. On a write, the red and green values are staged. The blue value completes the 30-bit word, commits it to the entry at the current address, and advances the address, which wraps from FFh to 00h. On a read, the whole entry is fetched on the red cycle and handed out one colour at a time. The bus width is selected through control register 0. Three formats are available: full 10-bit transfers, 8-bit transfers holding the upper colour bits, and a split format that carries each 10-bit colour in two bus cycles.

Top module: `hpal_port`

## Requirements
- R1: Register select 01 reaches the palette, 10 reaches the control register indexed by the address register, and 00 or 11 reach the address register. A read of the address register returns the address on D7:D0, with D9:D8 zero.
- R2: The colour pointer steps red, green, blue on each completed colour transfer. The blue write stores {red, green, blue} (red in bits 29:20) into the entry at the current address.
- R3: A write to the address register returns the colour pointer to red and discards any partly transferred colour sequence.
- R4: Every completed blue palette write adds one to the address register, and FFh wraps to 00h. Palette cycles that are not blue, and control accesses, leave the address unchanged.
- R5: Palette reads return the entry at the current address in the order red, green, blue. The entry is captured on the red cycle, and the address increments after the blue read.
- R6: Bits 1:0 of control register 0 select the bus format: 00 or 11 is 10-bit parallel, 01 is 8-bit, and 10 is split 8+2. After reset the format is 10-bit.
- R7: In 8-bit format, a palette write takes D7:D0 as colour bits 9:2 and stores zero in bits 1:0. A palette read returns colour bits 9:2 on D7:D0, with D9:D8 zero.
- R8: In split format, each colour takes two palette cycles. The first cycle carries colour bits 9:2 on D7:D0, and the second carries bits 1:0 on D1:D0. Reads use the same split, with all other bus bits zero.
- R9: Control registers are 8 bits wide and are written from D7:D0. Addresses from NUM_CTRL (default 9) upward read as zero, and writes to them are ignored.
- R10: The block drives the data bus only while the strobe is high with read selected. At all other times the bus is released.
- R11: Reset clears the address register and all control registers, and sets the colour pointer to red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hst_stb | input | 1 | Access strobe; one access per cycle while high |
| hst_rd | input | 1 | 1 = read, 0 = write |
| hst_sel | input | 2 | Register select (00/11 address, 01 palette, 10 control) |
| hst_data | inout | 10 | Bidirectional host data bus |

## Verification
The assertions assume that each strobe cycle is one complete access. They also assume that register select, read/write and write data are stable across the clock edge that closes the access. Finally, they assume that the bus format is not changed while a colour sequence is partly transferred. The bench drives every input on the falling edge and holds it through the next rising edge. Before any control-register write that changes the format, it writes the address register, so the pointer is back at red before the new format takes effect.

// File: rtl/hpal_pkg.sv
package hpal_pkg;
    localparam int ADDR_W = 8;
    localparam int COL_W  = 10;
    localparam int REG_W  = 8;
    localparam int PART_W = COL_W - 2;
    localparam int WORD_W = 3 * COL_W;

    localparam logic [1:0] SEL_ADR0 = 2'b00;
    localparam logic [1:0] SEL_PAL  = 2'b01;
    localparam logic [1:0] SEL_CTL  = 2'b10;

    typedef enum logic [1:0] {
        CP_RED = 2'd0,
        CP_GRN = 2'd1,
        CP_BLU = 2'd2
    } col_ptr_e;

    typedef enum logic [1:0] {
        BM_P10  = 2'd0,
        BM_P8   = 2'd1,
        BM_SPLT = 2'd2,
        BM_P10B = 2'd3
    } bus_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        col_ptr_e          ptr;
        logic              half;
        logic [PART_W-1:0] part;
        logic [COL_W-1:0]  stg_r;
        logic [COL_W-1:0]  stg_g;
        logic [WORD_W-1:0] hold;
    } seq_st_t;
endpackage

// File: rtl/hpal_ram.sv
module hpal_ram
    import hpal_pkg::*;
#(
    parameter int DEPTH = 2 ** ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/hpal_ctrl.sv
module hpal_ctrl
    import hpal_pkg::*;
#(
    parameter int NUM_CTRL = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output bus_mode_e         mode
);
    logic [REG_W-1:0] regs [NUM_CTRL];

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        logic hit;
        assign hit = we && (addr == ADDR_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (hit) begin
                regs[i] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_CTRL; k++) begin
            if (addr == ADDR_W'(k)) begin
                rdata = regs[k];
            end
        end
    end

    assign mode = bus_mode_e'(regs[0][1:0]);
endmodule

// File: rtl/hpal_busfmt.sv
module hpal_busfmt
    import hpal_pkg::*;
(
    input  bus_mode_e         mode,
    input  logic              half,
    input  logic [1:0]        sel,
    input  logic [COL_W-1:0]  wd,
    input  logic [PART_W-1:0] part,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  ctl_rd,
    input  logic [COL_W-1:0]  rcol,
    output logic [COL_W-1:0]  wval,
    output logic [COL_W-1:0]  rdata
);
    always_comb begin
        unique case (mode)
            BM_P8:   wval = {wd[PART_W-1:0], 2'b00};
            BM_SPLT: wval = {part, wd[1:0]};
            default: wval = wd;
        endcase
    end

    always_comb begin
        rdata = '0;
        if (sel == SEL_PAL) begin
            unique case (mode)
                BM_P8:   rdata = {2'b00, rcol[COL_W-1:2]};
                BM_SPLT: rdata = half ? {{(COL_W-2){1'b0}}, rcol[1:0]}
                                      : {2'b00, rcol[COL_W-1:2]};
                default: rdata = rcol;
            endcase
        end else if (sel == SEL_CTL) begin
            rdata = {{(COL_W-REG_W){1'b0}}, ctl_rd};
        end else begin
            rdata = {{(COL_W-ADDR_W){1'b0}}, addr};
        end
    end
endmodule

// File: rtl/hpal_seq.sv
module hpal_seq
    import hpal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              rd,
    input  logic [1:0]        sel,
    input  bus_mode_e         mode,
    input  logic [COL_W-1:0]  wd,
    input  logic [COL_W-1:0]  wval,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr,
    output col_ptr_e          ptr,
    output logic              half,
    output logic [PART_W-1:0] part,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              ctl_we,
    output logic [COL_W-1:0]  rcol
);
    seq_st_t st_d, st_q;
    logic is_pal, is_ctl, is_adr, last, fetch;
    logic [WORD_W-1:0] entry;

    always_comb begin
        st_d   = st_q;
        mem_we = 1'b0;
        ctl_we = 1'b0;
        is_pal = (sel == SEL_PAL);
        is_ctl = (sel == SEL_CTL);
        is_adr = !is_pal && !is_ctl;
        last   = (mode != BM_SPLT) || st_q.half;
        fetch  = (st_q.ptr == CP_RED) && !st_q.half;
        entry  = fetch ? mem_rdata : st_q.hold;

        unique case (st_q.ptr)
            CP_RED:  rcol = entry[WORD_W-1 -: COL_W];
            CP_GRN:  rcol = entry[2*COL_W-1 -: COL_W];
            default: rcol = entry[COL_W-1:0];
        endcase

        if (acc) begin
            if (is_adr && !rd) begin
                st_d.addr = wd[ADDR_W-1:0];
                st_d.ptr  = CP_RED;
                st_d.half = 1'b0;
            end else if (is_ctl && !rd) begin
                ctl_we = 1'b1;
            end else if (is_pal) begin
                if (rd && fetch) begin
                    st_d.hold = mem_rdata;
                end
                if (!last) begin
                    st_d.half = 1'b1;
                    if (!rd) begin
                        st_d.part = wd[PART_W-1:0];
                    end
                end else begin
                    st_d.half = 1'b0;
                    unique case (st_q.ptr)
                        CP_RED: begin
                            if (!rd) st_d.stg_r = wval;
                            st_d.ptr = CP_GRN;
                        end
                        CP_GRN: begin
                            if (!rd) st_d.stg_g = wval;
                            st_d.ptr = CP_BLU;
                        end
                        default: begin
                            mem_we    = !rd;
                            st_d.ptr  = CP_RED;
                            st_d.addr = st_q.addr + 1'b1;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, ptr: CP_RED, half: 1'b0, part: '0,
                      stg_r: '0, stg_g: '0, hold: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr      = st_q.addr;
    assign ptr       = st_q.ptr;
    assign half      = st_q.half;
    assign part      = st_q.part;
    assign mem_wdata = {st_q.stg_r, st_q.stg_g, wval};
endmodule

// File: rtl/hpal_port.sv
module hpal_port
    import hpal_pkg::*;
#(
    parameter int NUM_CTRL = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hst_stb,
    input  logic             hst_rd,
    input  logic [1:0]       hst_sel,
    inout  wire  [COL_W-1:0] hst_data
);
    logic [ADDR_W-1:0] addr;
    col_ptr_e          ptr;
    logic              half;
    logic [PART_W-1:0] part;
    logic              mem_we, ctl_we;
    logic [WORD_W-1:0] mem_wdata, mem_rdata;
    logic [COL_W-1:0]  wval, rcol, rdata, wd;
    logic [REG_W-1:0]  ctl_rd;
    bus_mode_e         mode;
    logic              drv;

    assign wd  = hst_data;
    assign drv = hst_stb && hst_rd;
    assign hst_data = drv ? rdata : {COL_W{1'bz}};

    hpal_seq u_seq (
        .clk(clk), .rst_n(rst_n), .acc(hst_stb), .rd(hst_rd), .sel(hst_sel),
        .mode(mode), .wd(wd), .wval(wval), .mem_rdata(mem_rdata),
        .addr(addr), .ptr(ptr), .half(half), .part(part), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .ctl_we(ctl_we), .rcol(rcol)
    );

    hpal_busfmt u_fmt (
        .mode(mode), .half(half), .sel(hst_sel), .wd(wd), .part(part),
        .addr(addr), .ctl_rd(ctl_rd), .rcol(rcol), .wval(wval), .rdata(rdata)
    );

    hpal_ctrl #(.NUM_CTRL(NUM_CTRL)) u_ctl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .addr(addr),
        .wdata(wd[REG_W-1:0]), .rdata(ctl_rd), .mode(mode)
    );

    hpal_ram u_ram (
        .clk(clk), .we(mem_we), .addr(addr), .wdata(mem_wdata), .rdata(mem_rdata)
    );
endmodule

// File: rtl/hpal_port_chk.sv
module hpal_port_chk
    import hpal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              stb,
    input logic              rd,
    input logic [1:0]        sel,
    input logic [ADDR_W-1:0] addr,
    input col_ptr_e          ptr,
    input logic              half,
    input bus_mode_e         mode
);
    logic colour_done;
    assign colour_done = (mode != BM_SPLT) || half;

    a_r4_incr_after_blue: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !rd && sel == SEL_PAL && ptr == CP_BLU && colour_done)
        |=> (addr == $past(addr) + 8'd1));

    a_r3_ptr_reset_on_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !rd && sel != SEL_PAL && sel != SEL_CTL)
        |=> (ptr == CP_RED && !half));

    a_r2_red_then_green: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && sel == SEL_PAL && ptr == CP_RED && colour_done)
        |=> (ptr == CP_GRN));

    a_r5_addr_hold_mid_read: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && rd && sel == SEL_PAL && ptr != CP_BLU)
        |=> $stable(addr));

    a_r6_mode_only_by_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb && !rd && sel == SEL_CTL) |=> $stable(mode));
endmodule

bind hpal_port hpal_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stb(hst_stb), .rd(hst_rd), .sel(hst_sel),
    .addr(addr), .ptr(ptr), .half(half), .mode(mode)
);

// File: tb/hpal_port_tb.sv
module hpal_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic       rd = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [9:0] tb_drv = '0;
    logic       tb_oe = 1'b0;
    wire  [9:0] hst_data;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    assign hst_data = tb_oe ? tb_drv : 10'bz;

    always #4 clk = ~clk;

    hpal_port u_dut (
        .clk(clk), .rst_n(rst_n), .hst_stb(stb), .hst_rd(rd),
        .hst_sel(sel), .hst_data(hst_data)
    );

    // fields: {tag[3:0], sel[1:0], rd, wdata[9:0], expected[9:0]}
    localparam int NV = 64;
    localparam logic [26:0] VEC [NV] = '{
        // R1 address register through both selects
        {4'd1,2'b00,1'b0,10'h005,10'h000}, {4'd1,2'b11,1'b1,10'h000,10'h005},
        // R2 write one entry, R4 address advanced
        {4'd2,2'b01,1'b0,10'h3A1,10'h000}, {4'd2,2'b01,1'b0,10'h155,10'h000},
        {4'd2,2'b01,1'b0,10'h2CC,10'h000}, {4'd4,2'b00,1'b1,10'h000,10'h006},
        // R5 read back
        {4'd1,2'b11,1'b0,10'h005,10'h000}, {4'd5,2'b01,1'b1,10'h000,10'h3A1},
        {4'd5,2'b01,1'b1,10'h000,10'h155}, {4'd5,2'b01,1'b1,10'h000,10'h2CC},
        {4'd5,2'b00,1'b1,10'h000,10'h006},
        // R9 control register, R1 address untouched
        {4'd1,2'b00,1'b0,10'h003,10'h000}, {4'd9,2'b10,1'b0,10'h0A7,10'h000},
        {4'd9,2'b10,1'b1,10'h000,10'h0A7}, {4'd1,2'b11,1'b1,10'h000,10'h003},
        // R3 partial sequence abandoned by address write
        {4'd3,2'b00,1'b0,10'h007,10'h000}, {4'd3,2'b01,1'b0,10'h111,10'h000},
        {4'd3,2'b00,1'b0,10'h007,10'h000}, {4'd3,2'b01,1'b0,10'h222,10'h000},
        {4'd3,2'b01,1'b0,10'h333,10'h000}, {4'd3,2'b01,1'b0,10'h044,10'h000},
        {4'd3,2'b00,1'b0,10'h007,10'h000}, {4'd3,2'b01,1'b1,10'h000,10'h222},
        {4'd3,2'b01,1'b1,10'h000,10'h333}, {4'd3,2'b01,1'b1,10'h000,10'h044},
        // R4 wrap FFh -> 00h on write, R5 on read
        {4'd4,2'b00,1'b0,10'h0FF,10'h000}, {4'd4,2'b01,1'b0,10'h3FF,10'h000},
        {4'd4,2'b01,1'b0,10'h000,10'h000}, {4'd4,2'b01,1'b0,10'h001,10'h000},
        {4'd4,2'b00,1'b1,10'h000,10'h000}, {4'd4,2'b00,1'b0,10'h0FF,10'h000},
        {4'd5,2'b01,1'b1,10'h000,10'h3FF}, {4'd5,2'b01,1'b1,10'h000,10'h000},
        {4'd5,2'b01,1'b1,10'h000,10'h001}, {4'd5,2'b11,1'b1,10'h000,10'h000},
        // R6 select 8-bit format, R7 transfers
        {4'd6,2'b00,1'b0,10'h000,10'h000}, {4'd6,2'b10,1'b0,10'h001,10'h000},
        {4'd6,2'b10,1'b1,10'h000,10'h001}, {4'd7,2'b00,1'b0,10'h010,10'h000},
        {4'd7,2'b01,1'b0,10'h3AB,10'h000}, {4'd7,2'b01,1'b0,10'h2CD,10'h000},
        {4'd7,2'b01,1'b0,10'h012,10'h000}, {4'd7,2'b00,1'b0,10'h010,10'h000},
        {4'd7,2'b01,1'b1,10'h000,10'h0AB}, {4'd7,2'b01,1'b1,10'h000,10'h0CD},
        {4'd7,2'b01,1'b1,10'h000,10'h012},
        // R6 select split format, R8 transfers
        {4'd6,2'b00,1'b0,10'h000,10'h000}, {4'd6,2'b10,1'b0,10'h002,10'h000},
        {4'd8,2'b00,1'b0,10'h020,10'h000}, {4'd8,2'b01,1'b0,10'h0E9,10'h000},
        {4'd8,2'b01,1'b0,10'h001,10'h000}, {4'd8,2'b01,1'b0,10'h03C,10'h000},
        {4'd8,2'b01,1'b0,10'h000,10'h000}, {4'd8,2'b01,1'b0,10'h0B5,10'h000},
        {4'd8,2'b01,1'b0,10'h003,10'h000}, {4'd8,2'b00,1'b1,10'h000,10'h021},
        {4'd8,2'b00,1'b0,10'h020,10'h000}, {4'd8,2'b01,1'b1,10'h000,10'h0E9},
        {4'd8,2'b01,1'b1,10'h000,10'h001}, {4'd8,2'b01,1'b1,10'h000,10'h03C},
        {4'd8,2'b01,1'b1,10'h000,10'h000}, {4'd8,2'b01,1'b1,10'h000,10'h0B5},
        {4'd8,2'b01,1'b1,10'h000,10'h003}, {4'd8,2'b00,1'b1,10'h000,10'h021}
    };

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %03h expected %03h", tag, act, exp);
        end
    endtask

    task automatic acc(input string tag, input logic [1:0] s, input logic r,
                       input logic [9:0] wdat, input logic [9:0] exp);
        @(negedge clk);
        stb = 1'b1; rd = r; sel = s; tb_drv = wdat; tb_oe = !r;
        #2;
        if (r) check(tag, hst_data, exp);
        @(posedge clk);
        #1;
        stb = 1'b0; tb_oe = 1'b0;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [26:0] v;
            v = VEC[i];
            acc($sformatf("R%0d", v[26:23]), v[22:21], v[20], v[19:10], v[9:0]);
        end

        // R6: back to 10-bit; R7 stored 8-bit writes as bits 9:2
        acc("R6", 2'b00, 1'b0, 10'h000, 10'h000);
        acc("R6", 2'b10, 1'b0, 10'h000, 10'h000);
        acc("R7", 2'b00, 1'b0, 10'h010, 10'h000);
        acc("R7", 2'b01, 1'b1, 10'h000, 10'h2AC);
        acc("R7", 2'b01, 1'b1, 10'h000, 10'h334);
        acc("R7", 2'b01, 1'b1, 10'h000, 10'h048);
        // R8 split writes rebuilt full colours; R6 format code 11 is 10-bit
        acc("R6", 2'b00, 1'b0, 10'h000, 10'h000);
        acc("R6", 2'b10, 1'b0, 10'h003, 10'h000);
        acc("R8", 2'b00, 1'b0, 10'h020, 10'h000);
        acc("R8", 2'b01, 1'b1, 10'h000, 10'h3A5);
        acc("R8", 2'b01, 1'b1, 10'h000, 10'h0F0);
        acc("R8", 2'b01, 1'b1, 10'h000, 10'h2D7);

        // R9 last valid register and out-of-range register
        acc("R9", 2'b00, 1'b0, 10'h008, 10'h000);
        acc("R9", 2'b10, 1'b0, 10'h03C, 10'h000);
        acc("R9", 2'b10, 1'b1, 10'h000, 10'h03C);
        acc("R9", 2'b00, 1'b0, 10'h040, 10'h000);
        acc("R9", 2'b10, 1'b0, 10'h05A, 10'h000);
        acc("R9", 2'b10, 1'b1, 10'h000, 10'h000);

        // R10 bus released when idle: bench value seen unaltered
        @(negedge clk);
        tb_oe = 1'b1; tb_drv = 10'h155;
        #2 check("R10", hst_data, 10'h155);
        @(negedge clk);
        sel = 2'b01; tb_drv = 10'h2AA;
        #2 check("R10", hst_data, 10'h2AA);
        tb_oe = 1'b0;

        // R11 reset in the middle of a colour sequence
        acc("R11", 2'b00, 1'b0, 10'h033, 10'h000);
        acc("R11", 2'b01, 1'b0, 10'h1F1, 10'h000);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        acc("R11", 2'b00, 1'b1, 10'h000, 10'h000);
        acc("R11", 2'b10, 1'b1, 10'h000, 10'h000);
        acc("R11", 2'b01, 1'b0, 10'h101, 10'h000);
        acc("R11", 2'b01, 1'b0, 10'h202, 10'h000);
        acc("R11", 2'b01, 1'b0, 10'h303, 10'h000);
        acc("R11", 2'b00, 1'b1, 10'h000, 10'h001);
        acc("R2", 2'b00, 1'b0, 10'h000, 10'h000);
        acc("R2", 2'b01, 1'b1, 10'h000, 10'h101);
        acc("R2", 2'b01, 1'b1, 10'h000, 10'h202);
        acc("R2", 2'b01, 1'b1, 10'h000, 10'h303);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule